// File: doc/BRIEF.md
# Halfword instruction expander

This block sits in an instruction fetch path between a 32-bit-wide instruction fetch port and an existing 32-bit instruction decoder. The processor has a state flag that selects between two instruction streams. When the flag is low, the fetched 32-bit word goes to the decoder unchanged. When the flag is high, the stream holds 16-bit compact instructions. The block then takes one halfword of the fetched word, picked by bit 1 of the program counter. It rewrites that halfword as the full 32-bit instruction that means the same thing, so the decoder itself needs no change.

The rewrite is a fixed table. Every compact register specifier is widened to four bits with a zero on top. The two-operand forms become three-operand forms by copying the destination field into the first-operand field. The flag-update bit, which the compact encoding implies, is written out. Every instruction except the short conditional branch gets the "always" condition.

The branch offset is counted in halfwords. It is halved into a word offset. The bit dropped by halving is passed beside the word as a marker, so that the decoder can add the extra halfword. Compact formats outside the supported set return a fixed filler word and raise an unsupported flag. A parameter selects a registered output (one cycle of latency, cleared by reset) or a purely combinational output.

Top module: `hx_expander`

## Requirements
- R1: With the state flag high, `pc_half` = 1 translates bits 31..16 of `fetch_word` and `pc_half` = 0 translates bits 15..0. The other half has no effect on any output.
- R2: With the state flag low, `out_word` equals `fetch_word`, and `out_unsupported` and `out_half_step` are 0, whatever `pc_half` is.
- R3: Every translated instruction other than the branch carries 4'hE in bits 31..28. Every 3-bit register field is placed in a 4-bit output field whose top bit is 0.
- R4: Compact `000110 A m[2:0] n[2:0] d[2:0]` becomes 0xE0000000 | op<<21 | 1<<20 | n<<16 | d<<12 | m, where op is 4'b0100 (add) when A = 0 and 4'b0010 (subtract) when A = 1. The immediate form `000111 A i[2:0] n d` is the same with bit 25 set and i in bits 2..0.
- R5: Compact `001 op[1:0] d[2:0] imm8` becomes a flag-setting immediate instruction with bit 25 set and imm8 in bits 7..0. op 00 is move (opcode 1101, bits 19..16 = 0, d in 15..12). op 01 is compare (opcode 1010, d in 19..16, bits 15..12 = 0). op 10 is add (0100) and op 11 is subtract (0010), both with d in 19..16 and in 15..12.
- R6: Compact `000 t[1:0] sh[4:0] m[2:0] d[2:0]` with t ≠ 11 becomes 0xE1B00000 | d<<12 | sh<<7 | t<<5 | m (a flag-setting move of shifted m).
- R7: Compact `11011111 imm8` becomes 0xEF000000 | imm8.
- R8: Compact `1101 c[3:0] off8` with c ≠ 1110 and c ≠ 1111 becomes c<<28 | 0x0A000000 | (off8 sign-extended and shifted right arithmetically by one, in 24 bits), with `out_half_step` = off8[0]. `out_half_step` is 0 for every other output.
- R9: Any other compact pattern, including `1101 1110 xxxxxxxx`, gives `out_unsupported` = 1 and `out_word` = UNSUP_WORD (default 0xE7F000F0).
- R10: With OUT_REG = 1, the outputs show the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R11: Every translated data-processing instruction (output bits 27..26 = 00) has bit 20 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_word | input | 32 | Fetched 32-bit word; in compact state it holds two halfwords, little-endian |
| pc_half | input | 1 | Program counter bit 1; selects the halfword |
| compact_mode | input | 1 | State flag; 1 = compact stream, 0 = full-width stream |
| out_word | output | 32 | Instruction presented to the full-width decoder |
| out_unsupported | output | 1 | Compact instruction outside the supported formats |
| out_half_step | output | 1 | Branch offset has an odd halfword left over |

## Verification
The hardest case to reach is a fetched word whose two halves belong to different formats. Only then does a wrong halfword choice change the result rather than repeat it. The stimulus builds such words on purpose: one half is a supported format and the other half is unsupported or another format, and both values of `pc_half` are applied. The branch condition boundary (1110 against 1111) and odd negative offsets are driven as directed patterns. A long random sweep follows, in which the mode flag and the halfword select change every cycle, so the registered output is checked back-to-back.

// File: rtl/hx_pkg.sv
package hx_pkg;

   typedef enum logic [2:0] {
      FMT_ADDSUB = 3'd0,
      FMT_SHIFT  = 3'd1,
      FMT_IMM8   = 3'd2,
      FMT_SWINT  = 3'd3,
      FMT_BRANCH = 3'd4,
      FMT_NONE   = 3'd5
   } hx_fmt_e;

   typedef struct packed {
      logic [31:0] word;
      logic        unsup;
      logic        half_step;
   } hx_result_t;

   localparam logic [3:0] COND_AL   = 4'b1110;
   localparam logic [3:0] OPC_ADD   = 4'b0100;
   localparam logic [3:0] OPC_SUB   = 4'b0010;
   localparam logic [3:0] OPC_CMP   = 4'b1010;
   localparam logic [3:0] OPC_MOV   = 4'b1101;
   localparam logic [2:0] CLS_BRCH  = 3'b101;
   localparam logic [3:0] CLS_TRAP  = 4'b1111;

endpackage

// File: rtl/hx_half_sel.sv
module hx_half_sel #(
   parameter int W = 32,
   localparam int HW = W / 2
) (
   input  logic [W-1:0]  word_i,
   input  logic          upper_i,
   output logic [HW-1:0] half_o
);
   // little-endian: the halfword at the higher address is the upper half
   assign half_o = upper_i ? word_i[W-1:HW] : word_i[HW-1:0];
endmodule

// File: rtl/hx_fmt_decode.sv
module hx_fmt_decode
   import hx_pkg::*;
(
   input  logic [15:0] hw_i,
   output hx_fmt_e     fmt_o
);
   logic is_addsub, is_shift, is_imm8, is_swint, is_branch;

   assign is_addsub = (hw_i[15:11] == 5'b00011);
   assign is_shift  = (hw_i[15:13] == 3'b000) && !is_addsub;
   assign is_imm8   = (hw_i[15:13] == 3'b001);
   assign is_swint  = (hw_i[15:8]  == 8'hDF);
   assign is_branch = (hw_i[15:12] == 4'hD) && (hw_i[11:9] != 3'b111);

   always_comb begin
      if (is_addsub)      fmt_o = FMT_ADDSUB;
      else if (is_shift)  fmt_o = FMT_SHIFT;
      else if (is_imm8)   fmt_o = FMT_IMM8;
      else if (is_swint)  fmt_o = FMT_SWINT;
      else if (is_branch) fmt_o = FMT_BRANCH;
      else                fmt_o = FMT_NONE;
   end
endmodule

// File: rtl/hx_xlate.sv
module hx_xlate
   import hx_pkg::*;
#(
   parameter logic [31:0] UNSUP_WORD = 32'hE7F0_00F0
) (
   input  logic [15:0] hw_i,
   input  hx_fmt_e     fmt_i,
   output hx_result_t  res_o
);
   logic [3:0] imm_opc;
   logic [3:0] imm_rn;
   logic [3:0] imm_rd;
   logic [3:0] rd_wide;
   logic [3:0] rn_wide;
   logic [3:0] rm_wide;
   logic [23:0] br_off;
   logic unused_top;

   assign unused_top = ^hw_i[15:13];

   // zero-extend the 3-bit register specifiers
   assign rd_wide = {1'b0, hw_i[2:0]};
   assign rn_wide = {1'b0, hw_i[5:3]};
   assign rm_wide = {1'b0, hw_i[8:6]};

   // halfword offset halved into a word offset, sign preserved
   assign br_off = {{17{hw_i[7]}}, hw_i[7:1]};

   always_comb begin
      unique case (hw_i[12:11])
         2'b00: begin imm_opc = OPC_MOV; imm_rn = 4'd0;            imm_rd = {1'b0, hw_i[10:8]}; end
         2'b01: begin imm_opc = OPC_CMP; imm_rn = {1'b0, hw_i[10:8]}; imm_rd = 4'd0;            end
         2'b10: begin imm_opc = OPC_ADD; imm_rn = {1'b0, hw_i[10:8]}; imm_rd = {1'b0, hw_i[10:8]}; end
         default: begin imm_opc = OPC_SUB; imm_rn = {1'b0, hw_i[10:8]}; imm_rd = {1'b0, hw_i[10:8]}; end
      endcase
   end

   always_comb begin
      res_o.word      = UNSUP_WORD;
      res_o.unsup     = 1'b1;
      res_o.half_step = 1'b0;
      unique case (fmt_i)
         FMT_ADDSUB: begin
            res_o.unsup = 1'b0;
            res_o.word  = {COND_AL, 2'b00, hw_i[10], (hw_i[9] ? OPC_SUB : OPC_ADD),
                           1'b1, rn_wide, rd_wide, 9'd0, hw_i[8:6]};
         end
         FMT_SHIFT: begin
            res_o.unsup = 1'b0;
            res_o.word  = {COND_AL, 2'b00, 1'b0, OPC_MOV, 1'b1, 4'd0, rd_wide,
                           hw_i[10:6], hw_i[12:11], 1'b0, rn_wide};
         end
         FMT_IMM8: begin
            res_o.unsup = 1'b0;
            res_o.word  = {COND_AL, 2'b00, 1'b1, imm_opc, 1'b1, imm_rn, imm_rd,
                           4'd0, hw_i[7:0]};
         end
         FMT_SWINT: begin
            res_o.unsup = 1'b0;
            res_o.word  = {COND_AL, CLS_TRAP, 16'd0, hw_i[7:0]};
         end
         FMT_BRANCH: begin
            res_o.unsup     = 1'b0;
            res_o.half_step = hw_i[0];
            res_o.word      = {hw_i[11:8], CLS_BRCH, 1'b0, br_off};
         end
         default: begin
            res_o.word      = UNSUP_WORD;
            res_o.unsup     = 1'b1;
            res_o.half_step = 1'b0;
         end
      endcase
   end

   // rm_wide is only used by the register add/sub path via hw_i[8:6]
   logic unused_rm;
   assign unused_rm = ^rm_wide;
endmodule

// File: rtl/hx_out_stage.sv
module hx_out_stage
   import hx_pkg::*;
#(
   parameter int OUT_REG = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  hx_result_t d_i,
   output hx_result_t q_o
);
   generate
      if (OUT_REG != 0) begin : g_reg
         hx_result_t q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d_i;
         end
         assign q_o = q_r;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q_o = d_i;
      end
   endgenerate
endmodule

// File: rtl/hx_expander.sv
module hx_expander
   import hx_pkg::*;
#(
   parameter int          FETCH_W    = 32,
   parameter int          OUT_REG    = 1,
   parameter logic [31:0] UNSUP_WORD = 32'hE7F0_00F0,
   localparam int         HALF_W     = FETCH_W / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FETCH_W-1:0] fetch_word,
   input  logic               pc_half,
   input  logic               compact_mode,
   output logic [FETCH_W-1:0] out_word,
   output logic               out_unsupported,
   output logic               out_half_step
);
   generate
      if (FETCH_W != 32) begin : g_bad_width
         $error("hx_expander: FETCH_W must be 32, the encodings are fixed");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
         $error("hx_expander: OUT_REG must be 0 or 1");
      end
   endgenerate

   logic [HALF_W-1:0] half_sel;
   hx_fmt_e           fmt;
   hx_result_t        xl_res;
   hx_result_t        raw_res;
   hx_result_t        pick_res;
   hx_result_t        out_res;

   hx_half_sel #(.W(FETCH_W)) u_half (
      .word_i  (fetch_word),
      .upper_i (pc_half),
      .half_o  (half_sel)
   );

   hx_fmt_decode u_dec (
      .hw_i  (half_sel),
      .fmt_o (fmt)
   );

   hx_xlate #(.UNSUP_WORD(UNSUP_WORD)) u_xl (
      .hw_i  (half_sel),
      .fmt_i (fmt),
      .res_o (xl_res)
   );

   assign raw_res.word      = fetch_word;
   assign raw_res.unsup     = 1'b0;
   assign raw_res.half_step = 1'b0;

   assign pick_res = compact_mode ? xl_res : raw_res;

   hx_out_stage #(.OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pick_res),
      .q_o   (out_res)
   );

   assign out_word        = out_res.word;
   assign out_unsupported = out_res.unsup;
   assign out_half_step   = out_res.half_step;
endmodule

// File: rtl/hx_expander_chk.sv
module hx_expander_chk #(
   parameter int          OUT_REG    = 1,
   parameter logic [31:0] UNSUP_WORD = 32'hE7F0_00F0
) (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] fetch_word,
   input logic        compact_mode,
   input logic [31:0] out_word,
   input logic        out_unsupported,
   input logic        out_half_step
);
   logic        v;
   logic [31:0] d_fetch;
   logic        d_mode;

   generate
      if (OUT_REG != 0) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v       <= 1'b0;
               d_fetch <= '0;
               d_mode  <= 1'b0;
            end else begin
               v       <= 1'b1;
               d_fetch <= fetch_word;
               d_mode  <= compact_mode;
            end
         end
      end else begin : g_live
         assign v       = 1'b1;
         assign d_fetch = fetch_word;
         assign d_mode  = compact_mode;
      end
   endgenerate

   logic xl_ok;
   assign xl_ok = v && d_mode && !out_unsupported;

   p_raw_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (v && !d_mode) |-> (out_word == d_fetch && !out_unsupported && !out_half_step));

   p_cond_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_ok && out_word[27:25] != 3'b101) |-> (out_word[31:28] == 4'hE));

   p_reg_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_ok && out_word[27:26] == 2'b00) |-> (!out_word[19] && !out_word[15]));

   p_cmp_no_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_ok && out_word[27:26] == 2'b00 && out_word[24:21] == 4'b1010)
      |-> (out_word[15:12] == 4'd0));

   p_trap_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_ok && out_word[27:24] == 4'hF) |-> (out_word[23:8] == 16'd0));

   p_half_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_half_step |-> (d_mode && out_word[27:25] == 3'b101 && !out_unsupported));

   p_unsup_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_unsupported |-> (d_mode && out_word == UNSUP_WORD));

   p_sets_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_ok && out_word[27:26] == 2'b00) |-> out_word[20]);
endmodule

bind hx_expander hx_expander_chk #(.OUT_REG(OUT_REG), .UNSUP_WORD(UNSUP_WORD)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .fetch_word      (fetch_word),
   .compact_mode    (compact_mode),
   .out_word        (out_word),
   .out_unsupported (out_unsupported),
   .out_half_step   (out_half_step)
);

// File: tb/hx_expander_bench.sv
`timescale 1ns/1ps
module hx_expander_bench;
   localparam logic [31:0] UNSUP = 32'hE7F0_00F0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_word = '0;
   logic        pc_half = 1'b0;
   logic        compact_mode = 1'b0;
   logic [31:0] out_word;
   logic        out_unsupported;
   logic        out_half_step;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // pending expectation for the registered output (one cycle)
   bit          pend = 1'b0;
   logic [31:0] e_word;
   logic        e_unsup;
   logic        e_hs;
   string       e_tag;
   bit          e_dp;

   always #2.5 clk = ~clk;

   hx_expander u_hx_expander (
      .clk             (clk),
      .rst_n           (rst_n),
      .fetch_word      (fetch_word),
      .pc_half         (pc_half),
      .compact_mode    (compact_mode),
      .out_word        (out_word),
      .out_unsupported (out_unsupported),
      .out_half_step   (out_half_step)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural model of the translation table
   function automatic void model(input logic [15:0] h, output logic [31:0] w,
                                 output logic u, output logic hs,
                                 output string tag, output bit dp);
      int d, n, m, op, imm;
      d = int'(h[2:0]); n = int'(h[5:3]); m = int'(h[8:6]);
      u = 1'b0; hs = 1'b0; dp = 1'b0;
      if (h[15:11] == 5'b00011) begin
         tag = "R4"; dp = 1'b1;
         w = 32'hE010_0000 | ((h[9] ? 32'h2 : 32'h4) << 21) | (32'(n) << 16) | (32'(d) << 12) | 32'(m);
         if (h[10]) w = w | 32'h0200_0000;
      end else if (h[15:13] == 3'b000) begin
         tag = "R6"; dp = 1'b1;
         w = 32'hE1B0_0000 | (32'(d) << 12) | (32'(h[10:6]) << 7) | (32'(h[12:11]) << 5) | 32'(n);
      end else if (h[15:13] == 3'b001) begin
         tag = "R5"; dp = 1'b1;
         d = int'(h[10:8]); imm = int'(h[7:0]); op = int'(h[12:11]);
         case (op)
            0: w = 32'hE3B0_0000 | (32'(d) << 12) | 32'(imm);
            1: w = 32'hE350_0000 | (32'(d) << 16) | 32'(imm);
            2: w = 32'hE290_0000 | (32'(d) << 16) | (32'(d) << 12) | 32'(imm);
            default: w = 32'hE250_0000 | (32'(d) << 16) | (32'(d) << 12) | 32'(imm);
         endcase
      end else if (h[15:8] == 8'hDF) begin
         tag = "R7";
         w = 32'hEF00_0000 | 32'(h[7:0]);
      end else if (h[15:12] == 4'hD && h[11:8] != 4'hE) begin
         int off;
         tag = "R8";
         off = int'($signed(h[7:0])) >>> 1;
         w = (32'(h[11:8]) << 28) | 32'h0A00_0000 | (32'(off) & 32'h00FF_FFFF);
         hs = h[0];
      end else begin
         tag = "R9";
         w = UNSUP; u = 1'b1;
      end
   endfunction

   task automatic check_pending();
      if (pend) begin
         chk({e_tag, " word"}, out_word, e_word);
         chk({e_tag, " unsupported"}, {31'd0, out_unsupported}, {31'd0, e_unsup});
         chk({e_tag, " half step"}, {31'd0, out_half_step}, {31'd0, e_hs});
         if (e_dp) begin
            chk("R3 cond and register top bits", {out_word[31:28], 2'b00, out_word[19], out_word[15]},
                {4'hE, 2'b00, 1'b0, 1'b0});
            chk("R11 flag bit", {31'd0, out_word[20]}, 32'd1);
         end
      end
   endtask

   // one cycle: check result of previous inputs, then drive new ones
   task automatic step(input logic [31:0] fw, input logic ph, input logic md, input string force_tag);
      logic [15:0] h;
      @(negedge clk);
      check_pending();
      fetch_word = fw; pc_half = ph; compact_mode = md;
      if (md) begin
         h = ph ? fw[31:16] : fw[15:0];
         model(h, e_word, e_unsup, e_hs, e_tag, e_dp);
      end else begin
         e_word = fw; e_unsup = 1'b0; e_hs = 1'b0; e_tag = "R2"; e_dp = 1'b0;
      end
      if (force_tag != "") e_tag = {force_tag, "/", e_tag};
      pend = 1'b1;
   endtask

   task automatic both_halves(input logic [15:0] a, input logic [15:0] b);
      step({a, b}, 1'b1, 1'b1, "R1");
      step({a, b}, 1'b0, 1'b1, "R1");
      step({b, a}, 1'b0, 1'b1, "R1");
      step({b, a}, 1'b1, 1'b1, "R1");
   endtask

   initial begin
      // R10: outputs held at zero while reset is low
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R10 reset word", out_word, 32'd0);
         chk("R10 reset flags", {30'd0, out_unsupported, out_half_step}, 32'd0);
         fetch_word = 32'hDF12_BE00 ^ (32'(i) << 4);
         compact_mode = i[0];
         pc_half = i[1];
      end
      @(negedge clk);
      rst_n = 1'b1;
      pend = 1'b0;

      // R4 register and immediate add/subtract
      step({16'h0, 16'h1888}, 1'b0, 1'b1, "");
      step({16'h1A5F, 16'h0}, 1'b1, 1'b1, "");
      step({16'h0, 16'h1D3A}, 1'b0, 1'b1, "");
      step({16'h0, 16'h1FFF}, 1'b0, 1'b1, "");
      // R5 all four minor opcodes
      step({16'h0, 16'h2355}, 1'b0, 1'b1, "");
      step({16'h0, 16'h2CFF}, 1'b0, 1'b1, "");
      step({16'h0, 16'h3280}, 1'b0, 1'b1, "");
      step({16'h0, 16'h3F01}, 1'b0, 1'b1, "");
      // R6 shifts: left, logical right, arithmetic right
      step({16'h0, 16'h07FF}, 1'b0, 1'b1, "");
      step({16'h0, 16'h0840}, 1'b0, 1'b1, "");
      step({16'h0, 16'h1111}, 1'b0, 1'b1, "");
      // R7 software interrupt
      step({16'hDFAB, 16'h0}, 1'b1, 1'b1, "");
      step({16'h0, 16'hDF00}, 1'b0, 1'b1, "");
      // R8 branch: positive even, negative odd, cond boundary
      step({16'h0, 16'hD07E}, 1'b0, 1'b1, "");
      step({16'h0, 16'hD1FF}, 1'b0, 1'b1, "");
      step({16'h0, 16'hDD81}, 1'b0, 1'b1, "");
      // R9 unsupported including cond 1110
      step({16'h0, 16'hDE10}, 1'b0, 1'b1, "");
      step({16'h0, 16'h4000}, 1'b0, 1'b1, "");
      step({16'hF800, 16'h0}, 1'b1, 1'b1, "");
      // R2 raw pass-through with both selects
      step(32'hDEAD_BEEF, 1'b0, 1'b0, "");
      step(32'h1234_5678, 1'b1, 1'b0, "");
      // R1 halves from different formats
      both_halves(16'h2CFF, 16'h4000);
      both_halves(16'hD1FF, 16'h1A5F);
      both_halves(16'hDFAB, 16'h07FF);

      // random sweep, R10 back-to-back
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         if (i % 4 == 0) r[15:12] = 4'hD;
         if (i % 5 == 0) r[31:29] = 3'b001;
         step(r, r[7] ^ r[22], (i % 3) != 0, "");
      end
      @(negedge clk);
      check_pending();
      pend = 1'b0;

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule